// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write side of a parallel flash interface and turns a stream of single-cycle bus writes (address plus data) into decoded commands for a separate program/erase engine. Each command begins with a two-write unlock preamble. The command byte and any trailing writes follow it. The decoder tracks its position in the sequence and emits a one-cycle strobe when a command completes. A program command also delivers its target address and data. A block erase delivers a bitmask of the selected blocks.

A small mode register records whether the part is in plain read, identifier read (auto-select), unlock-bypass, or erase-suspended mode. A byte-mode input selects between the 8-bit and the 16-bit address mapping for the unlock addresses and for the block lookup. The engine reports `busy` while an operation runs. While it is high, only suspend and reset are accepted. A separate timeout input closes the window in which further blocks can be added to a block erase.

Top module: `flcmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), every strobe is low and `blk_mask` is 0.
- R2: In word mode (`byte_mode`=0) the preamble is AAh at 555h then 55h at 2AAh, and the command address is 555h; only `wr_addr[10:0]` is compared. In byte mode the preamble is AAh at AAAh then 55h at 555h, the command address is AAAh, and only `wr_addr[11:0]` is compared (bit 0 is the byte-select line). Only `wr_data[7:0]` is decoded.
- R3: Preamble plus 90h at the command address pulses `asel_stb`, sets `mode` to 1, and the mode holds until another command is accepted.
- R4: Preamble plus A0h at the command address, then one more write, pulses `prog_stb` in the cycle after that write, with `prog_addr`/`prog_data` equal to its address and full data.
- R5: Preamble plus 20h sets `mode` to 2 (bypass). In bypass, A0h at any address followed by one write programs as in R4 and `mode` stays 2. 90h followed by 00h returns `mode` to 0.
- R6: Preamble, 80h at the command address, a second preamble, then 10h at the command address pulses `chip_erase_stb`.
- R7: The same erase sequence ending in 30h at any address opens a block list, and each later 30h write adds its block. When `erase_tmo` rises, `blk_erase_stb` pulses with `blk_mask` bit i set for each listed block. The block of a word address w is w[17:15] when w < 38000h; w in 38000h–3BFFFh is 7, 3C000h–3CFFFh is 8, 3D000h–3DFFFh is 9, and 3E000h–3FFFFh is 10. In byte mode w is `wr_addr[18:1]`.
- R8: A write that arrives in the same cycle as `erase_tmo` while the list is open is discarded. It is not added to `blk_mask`, and it does not start a new sequence.
- R9: F0h written alone to any address, or after a preamble, pulses `rst_stb` and sets `mode` to 0.
- R10: A write that does not continue a valid sequence produces no strobe and sets `mode` to 0 (to 3 if suspended).
- R11: While `busy` is high, writes are ignored except F0h (R9) and B0h. B0h pulses `susp_stb` and sets `mode` to 3.
- R12: In mode 3, a program command (R4) is accepted and leaves `mode` at 3. A 30h write to any address pulses `resume_stb` and sets `mode` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects the 8-bit address mapping |
| busy | input | 1 | Program/erase engine is running |
| erase_tmo | input | 1 | Block-erase collection window has expired |
| wr_en | input | 1 | A bus write is presented this cycle |
| wr_addr | input | 19 | Write address |
| wr_data | input | 16 | Write data |
| mode | output | 2 | 0 read, 1 auto-select, 2 bypass, 3 suspended |
| rst_stb | output | 1 | Reset command accepted |
| asel_stb | output | 1 | Auto-select entered |
| prog_stb | output | 1 | Program request |
| prog_addr | output | 19 | Address of the program request |
| prog_data | output | 16 | Data of the program request |
| chip_erase_stb | output | 1 | Chip erase request |
| blk_erase_stb | output | 1 | Block erase request |
| blk_mask | output | 11 | Blocks selected for the block erase |
| susp_stb | output | 1 | Erase suspend request |
| resume_stb | output | 1 | Erase resume request |

## Verification
A block-list append and the closing of that list can fall in the same cycle: a 30h write to a new block and `erase_tmo` arrive together. The bench provokes this by driving both on one clock edge after a one-block list has been opened. The test passes when the strobe carries only the earlier block. Mode must stay at read, and a second timeout pulse must give no strobe, which shows that the colliding write opened no new list.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
    typedef enum logic [1:0] {
        MD_READ = 2'd0,
        MD_ASEL = 2'd1,
        MD_BYP  = 2'd2,
        MD_SUSP = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM,
        SQ_ER1, SQ_ER2, SQ_ER3, SQ_COLL,
        SQ_BPGM, SQ_BEXIT
    } seq_e;

    localparam logic [7:0] OP_UNL1  = 8'hAA;
    localparam logic [7:0] OP_UNL2  = 8'h55;
    localparam logic [7:0] OP_ASEL  = 8'h90;
    localparam logic [7:0] OP_PGM   = 8'hA0;
    localparam logic [7:0] OP_BYP   = 8'h20;
    localparam logic [7:0] OP_ERASE = 8'h80;
    localparam logic [7:0] OP_CHIP  = 8'h10;
    localparam logic [7:0] OP_BLK   = 8'h30;
    localparam logic [7:0] OP_RST   = 8'hF0;
    localparam logic [7:0] OP_SUSP  = 8'hB0;
    localparam logic [7:0] OP_BEXIT = 8'h00;
endpackage

// File: rtl/flcmd_addr_cmp.sv
module flcmd_addr_cmp #(
    parameter int CMP_W = 12
) (
    input  logic [CMP_W-1:0] addr_lo,
    input  logic             byte_mode,
    output logic             hit_cmd,
    output logic             hit_alt
);
    localparam int WORD_W = CMP_W - 1;

    localparam logic [WORD_W-1:0] W_CMD = WORD_W'(11'h555);
    localparam logic [WORD_W-1:0] W_ALT = WORD_W'(11'h2AA);
    localparam logic [CMP_W-1:0]  B_CMD = CMP_W'(12'hAAA);
    localparam logic [CMP_W-1:0]  B_ALT = CMP_W'(12'h555);

    always_comb begin
        if (byte_mode) begin
            hit_cmd = (addr_lo == B_CMD);
            hit_alt = (addr_lo == B_ALT);
        end else begin
            hit_cmd = (addr_lo[WORD_W-1:0] == W_CMD);
            hit_alt = (addr_lo[WORD_W-1:0] == W_ALT);
        end
    end
endmodule

// File: rtl/flcmd_blk_map.sv
module flcmd_blk_map #(
    parameter int ADDR_W = 19,
    parameter int NBLK   = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_mode,
    output logic [NBLK-1:0]   blk_oh
);
    localparam int WA_W  = ADDR_W - 1;
    localparam int TOP_L = WA_W - 3;
    localparam int IDX_W = $clog2(NBLK);

    logic [WA_W-1:0]  wa;
    logic [2:0]       top;
    logic [IDX_W-1:0] idx;

    always_comb begin
        wa  = byte_mode ? addr[ADDR_W-1:1] : addr[WA_W-1:0];
        top = wa[WA_W-1:TOP_L];
        if (top != 3'd7)
            idx = IDX_W'(top);
        else if (!wa[TOP_L-1])
            idx = IDX_W'(7);
        else if (wa[TOP_L-2])
            idx = IDX_W'(10);
        else if (wa[TOP_L-3])
            idx = IDX_W'(9);
        else
            idx = IDX_W'(8);
    end

    for (genvar i = 0; i < NBLK; i++) begin : g_oh
        assign blk_oh[i] = (idx == IDX_W'(i));
    end
endmodule

// File: rtl/flcmd_decoder.sv
module flcmd_decoder
    import flcmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int NBLK   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              busy,
    input  logic              erase_tmo,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        mode,
    output logic              rst_stb,
    output logic              asel_stb,
    output logic              prog_stb,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              chip_erase_stb,
    output logic              blk_erase_stb,
    output logic [NBLK-1:0]   blk_mask,
    output logic              susp_stb,
    output logic              resume_stb
);
    localparam int CMP_W = 12;

    typedef struct packed {
        seq_e              seq;
        mode_e             mode;
        logic [NBLK-1:0]   list;
        logic              rst_stb;
        logic              asel_stb;
        logic              prog_stb;
        logic              chip_stb;
        logic              blk_stb;
        logic              susp_stb;
        logic              res_stb;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
        logic [NBLK-1:0]   bmask;
    } st_t;

    st_t st_d, st_q;

    logic            hit_cmd, hit_alt;
    logic [NBLK-1:0] blk_oh;
    logic [7:0]      op;
    logic            brk;

    flcmd_addr_cmp #(.CMP_W(CMP_W)) u_cmp (
        .addr_lo   (wr_addr[CMP_W-1:0]),
        .byte_mode (byte_mode),
        .hit_cmd   (hit_cmd),
        .hit_alt   (hit_alt)
    );

    flcmd_blk_map #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_map (
        .addr      (wr_addr),
        .byte_mode (byte_mode),
        .blk_oh    (blk_oh)
    );

    assign op = wr_data[7:0];

    always_comb begin
        st_d          = st_q;
        st_d.rst_stb  = 1'b0;
        st_d.asel_stb = 1'b0;
        st_d.prog_stb = 1'b0;
        st_d.chip_stb = 1'b0;
        st_d.blk_stb  = 1'b0;
        st_d.susp_stb = 1'b0;
        st_d.res_stb  = 1'b0;
        brk           = 1'b0;

        if (st_q.seq == SQ_COLL && erase_tmo) begin
            // closing the list wins over any write in the same cycle
            st_d.blk_stb = 1'b1;
            st_d.bmask   = st_q.list;
            st_d.list    = '0;
            st_d.seq     = SQ_IDLE;
        end else if (wr_en) begin
            if (busy && st_q.seq != SQ_COLL) begin
                if (op == OP_RST) begin
                    st_d.rst_stb = 1'b1;
                    st_d.mode    = MD_READ;
                    st_d.seq     = SQ_IDLE;
                    st_d.list    = '0;
                end else if (op == OP_SUSP && st_q.mode != MD_SUSP) begin
                    st_d.susp_stb = 1'b1;
                    st_d.mode     = MD_SUSP;
                    st_d.seq      = SQ_IDLE;
                end
            end else if (st_q.seq == SQ_PGM || st_q.seq == SQ_BPGM) begin
                st_d.prog_stb = 1'b1;
                st_d.paddr    = wr_addr;
                st_d.pdata    = wr_data;
                st_d.seq      = SQ_IDLE;
                if (st_q.seq == SQ_PGM)
                    st_d.mode = (st_q.mode == MD_SUSP) ? MD_SUSP : MD_READ;
            end else if (op == OP_RST) begin
                st_d.rst_stb = 1'b1;
                st_d.mode    = MD_READ;
                st_d.seq     = SQ_IDLE;
                st_d.list    = '0;
            end else begin
                case (st_q.seq)
                    SQ_IDLE: begin
                        if (st_q.mode == MD_BYP) begin
                            if (op == OP_PGM)       st_d.seq = SQ_BPGM;
                            else if (op == OP_ASEL) st_d.seq = SQ_BEXIT;
                            else                    brk = 1'b1;
                        end else if (st_q.mode == MD_SUSP && op == OP_BLK) begin
                            st_d.res_stb = 1'b1;
                            st_d.mode    = MD_READ;
                        end else if (hit_cmd && op == OP_UNL1) begin
                            st_d.seq = SQ_UNL1;
                        end else begin
                            brk = 1'b1;
                        end
                    end
                    SQ_UNL1: begin
                        if (hit_alt && op == OP_UNL2) st_d.seq = SQ_UNL2;
                        else                          brk = 1'b1;
                    end
                    SQ_UNL2: begin
                        if (!hit_cmd) begin
                            brk = 1'b1;
                        end else if (op == OP_ASEL) begin
                            st_d.asel_stb = 1'b1;
                            st_d.seq      = SQ_IDLE;
                            st_d.mode     = (st_q.mode == MD_SUSP) ? MD_SUSP : MD_ASEL;
                        end else if (op == OP_PGM) begin
                            st_d.seq = SQ_PGM;
                        end else if (op == OP_BYP && st_q.mode != MD_SUSP) begin
                            st_d.seq  = SQ_IDLE;
                            st_d.mode = MD_BYP;
                        end else if (op == OP_ERASE && st_q.mode != MD_SUSP) begin
                            st_d.seq = SQ_ER1;
                        end else begin
                            brk = 1'b1;
                        end
                    end
                    SQ_ER1: begin
                        if (hit_cmd && op == OP_UNL1) st_d.seq = SQ_ER2;
                        else                          brk = 1'b1;
                    end
                    SQ_ER2: begin
                        if (hit_alt && op == OP_UNL2) st_d.seq = SQ_ER3;
                        else                          brk = 1'b1;
                    end
                    SQ_ER3: begin
                        if (hit_cmd && op == OP_CHIP) begin
                            st_d.chip_stb = 1'b1;
                            st_d.seq      = SQ_IDLE;
                            st_d.mode     = MD_READ;
                        end else if (op == OP_BLK) begin
                            st_d.list = blk_oh;
                            st_d.seq  = SQ_COLL;
                            st_d.mode = MD_READ;
                        end else begin
                            brk = 1'b1;
                        end
                    end
                    SQ_COLL: begin
                        if (op == OP_BLK) st_d.list = st_q.list | blk_oh;
                        else              brk = 1'b1;
                    end
                    SQ_BEXIT: begin
                        st_d.seq  = SQ_IDLE;
                        st_d.mode = MD_READ;
                        if (op != OP_BEXIT) brk = 1'b1;
                    end
                    default: brk = 1'b1;
                endcase
            end
        end

        if (brk) begin
            st_d.seq  = SQ_IDLE;
            st_d.list = '0;
            st_d.mode = (st_q.mode == MD_SUSP) ? MD_SUSP : MD_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{seq: SQ_IDLE, mode: MD_READ, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode           = st_q.mode;
    assign rst_stb        = st_q.rst_stb;
    assign asel_stb       = st_q.asel_stb;
    assign prog_stb       = st_q.prog_stb;
    assign prog_addr      = st_q.paddr;
    assign prog_data      = st_q.pdata;
    assign chip_erase_stb = st_q.chip_stb;
    assign blk_erase_stb  = st_q.blk_stb;
    assign blk_mask       = st_q.bmask;
    assign susp_stb       = st_q.susp_stb;
    assign resume_stb     = st_q.res_stb;
endmodule

// File: rtl/flcmd_chk.sv
module flcmd_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int NBLK   = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              erase_tmo,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        mode,
    input logic              rst_stb,
    input logic              asel_stb,
    input logic              prog_stb,
    input logic              chip_erase_stb,
    input logic              blk_erase_stb,
    input logic [NBLK-1:0]   blk_mask,
    input logic              susp_stb,
    input logic              resume_stb
);
    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_stb, asel_stb, prog_stb, chip_erase_stb,
                  blk_erase_stb, susp_stb, resume_stb}));

    // R10
    quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(mode));

    // R4
    prog_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |-> $past(wr_en && !busy));

    // R6
    chip_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_stb |-> $past(wr_en && !busy && wr_data[7:0] == 8'h10));

    // R7
    blk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_erase_stb |-> ($past(erase_tmo) && blk_mask != '0));

    // R3
    asel_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asel_stb |-> (mode == 2'd1 || mode == 2'd3));

    // R9
    rst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_stb |-> (mode == 2'd0 && $past(wr_en && wr_data[7:0] == 8'hF0)));

    // R11
    susp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_stb |-> (mode == 2'd3 && $past(busy && wr_en && wr_data[7:0] == 8'hB0)));

    // R12
    resume_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_stb |-> ($past(mode) == 2'd3 && mode == 2'd0));
endmodule

bind flcmd_decoder flcmd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBLK(NBLK)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .erase_tmo      (erase_tmo),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .mode           (mode),
    .rst_stb        (rst_stb),
    .asel_stb       (asel_stb),
    .prog_stb       (prog_stb),
    .chip_erase_stb (chip_erase_stb),
    .blk_erase_stb  (blk_erase_stb),
    .blk_mask       (blk_mask),
    .susp_stb       (susp_stb),
    .resume_stb     (resume_stb)
);

// File: tb/sim_flcmd_decoder.sv
module sim_flcmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_mode = 1'b0;
    logic        busy = 1'b0;
    logic        erase_tmo = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  mode;
    logic        rst_stb, asel_stb, prog_stb, chip_erase_stb;
    logic        blk_erase_stb, susp_stb, resume_stb;
    logic [18:0] prog_addr;
    logic [15:0] prog_data;
    logic [10:0] blk_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // strobes captured one cycle after the last write or pulse
    logic [6:0] s_stb;   // {rst, asel, prog, chip, blk, susp, resume}

    always #2 clk = ~clk;

    flcmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .busy(busy),
        .erase_tmo(erase_tmo), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode(mode), .rst_stb(rst_stb), .asel_stb(asel_stb), .prog_stb(prog_stb),
        .prog_addr(prog_addr), .prog_data(prog_data), .chip_erase_stb(chip_erase_stb),
        .blk_erase_stb(blk_erase_stb), .blk_mask(blk_mask), .susp_stb(susp_stb),
        .resume_stb(resume_stb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic snap();
        s_stb = {rst_stb, asel_stb, prog_stb, chip_erase_stb,
                 blk_erase_stb, susp_stb, resume_stb};
    endtask

    task automatic wr(input logic [18:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        snap();
    endtask

    task automatic tmo();
        @(negedge clk);
        erase_tmo = 1'b1;
        @(negedge clk);
        erase_tmo = 1'b0;
        snap();
    endtask

    task automatic pre();
        if (byte_mode) begin wr(19'hAAA, 16'h00AA); wr(19'h555, 16'h0055); end
        else           begin wr(19'h555, 16'h00AA); wr(19'h2AA, 16'h0055); end
    endtask

    function automatic logic [18:0] ca();
        return byte_mode ? 19'hAAA : 19'h555;
    endfunction

    task automatic t_reset();
        snap();
        chk("R1 mode", 32'(mode), 0);
        chk("R1 strobes", 32'(s_stb), 0);
        chk("R1 blk_mask", 32'(blk_mask), 0);
    endtask

    task automatic t_asel_f0();
        pre(); wr(ca(), 16'h0090);
        chk("R3 asel_stb", 32'(s_stb), 32'h20);
        repeat (3) @(negedge clk);
        chk("R3 mode held", 32'(mode), 1);
        wr(19'h01234, 16'h00F0);
        chk("R9 single F0 strobe", 32'(s_stb), 32'h40);
        chk("R9 mode", 32'(mode), 0);
        pre(); wr(19'h00777, 16'h00F0);
        chk("R9 F0 after preamble", 32'(s_stb), 32'h40);
    endtask

    task automatic t_map();
        wr(19'h7F555, 16'hFFAA); wr(19'h7D2AA, 16'h1255); wr(19'h40555, 16'hAB90);
        chk("R2 high bits ignored", 32'(s_stb), 32'h20);
        wr(19'h0, 16'h00F0);
        byte_mode = 1'b1;
        pre(); wr(19'hAAA, 16'h0090);
        chk("R2 byte map asel", 32'(s_stb), 32'h20);
        wr(19'h0, 16'h00F0);
        wr(19'h555, 16'h00AA); wr(19'h2AA, 16'h0055); wr(19'h555, 16'h0090);
        chk("R2 word addrs in byte mode", 32'(s_stb), 0);
        chk("R2 mode stays read", 32'(mode), 0);
        byte_mode = 1'b0;
    endtask

    task automatic t_prog();
        pre(); wr(19'h555, 16'h00A0); wr(19'h2ABCD, 16'hC3A5);
        chk("R4 prog_stb", 32'(s_stb), 32'h10);
        chk("R4 prog_addr", 32'(prog_addr), 32'h2ABCD);
        chk("R4 prog_data", 32'(prog_data), 32'hC3A5);
    endtask

    task automatic t_bypass();
        pre(); wr(19'h555, 16'h0020);
        chk("R5 bypass mode", 32'(mode), 2);
        wr(19'h00777, 16'h00A0); wr(19'h12345, 16'h5AA5);
        chk("R5 bypass prog", 32'(s_stb), 32'h10);
        chk("R5 bypass addr", 32'(prog_addr), 32'h12345);
        chk("R5 still bypass", 32'(mode), 2);
        wr(19'h0, 16'h0090); wr(19'h0, 16'h0000);
        chk("R5 bypass exit", 32'(mode), 0);
    endtask

    task automatic t_chip();
        pre(); wr(ca(), 16'h0080); pre(); wr(ca(), 16'h0010);
        chk("R6 chip erase", 32'(s_stb), 32'h08);
    endtask

    task automatic t_blk();
        pre(); wr(19'h555, 16'h0080); pre();
        wr(19'h08000, 16'h0030); wr(19'h3D123, 16'h0030);
        tmo();
        chk("R7 blk strobe", 32'(s_stb), 32'h04);
        chk("R7 word mask", 32'(blk_mask), 32'h202);
        byte_mode = 1'b1;
        pre(); wr(19'hAAA, 16'h0080); pre();
        wr(19'h7C000, 16'h0030); wr(19'h78000, 16'h0030);
        tmo();
        chk("R7 byte mask", 32'(blk_mask), 32'h500);
        byte_mode = 1'b0;
    endtask

    task automatic t_same_cycle();
        pre(); wr(19'h555, 16'h0080); pre(); wr(19'h00010, 16'h0030);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 19'h10000; wr_data = 16'h0030; erase_tmo = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; erase_tmo = 1'b0;
        snap();
        chk("R8 strobe", 32'(s_stb), 32'h04);
        chk("R8 mask excludes late write", 32'(blk_mask), 32'h001);
        chk("R8 mode", 32'(mode), 0);
        tmo();
        chk("R8 no second list", 32'(s_stb), 0);
    endtask

    task automatic t_break();
        pre(); wr(19'h555, 16'h0090);
        wr(19'h555, 16'h00AA);
        chk("R10 mode held mid-sequence", 32'(mode), 1);
        wr(19'h00123, 16'h0055);
        chk("R10 break strobes", 32'(s_stb), 0);
        chk("R10 break mode", 32'(mode), 0);
    endtask

    task automatic t_busy_susp();
        busy = 1'b1;
        pre();
        busy = 1'b0;
        wr(19'h555, 16'h0090);
        chk("R11 preamble ignored while busy", 32'(s_stb), 0);
        busy = 1'b1;
        wr(19'h00333, 16'h00B0);
        chk("R11 suspend strobe", 32'(s_stb), 32'h02);
        chk("R11 suspend mode", 32'(mode), 3);
        busy = 1'b0;
        pre(); wr(19'h555, 16'h00A0); wr(19'h00100, 16'h1234);
        chk("R12 prog in suspend", 32'(s_stb), 32'h10);
        chk("R12 mode kept", 32'(mode), 3);
        wr(19'h00055, 16'h0030);
        chk("R12 resume strobe", 32'(s_stb), 32'h01);
        chk("R12 resume mode", 32'(mode), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_asel_f0();
        t_map();
        t_prog();
        t_bypass();
        t_chip();
        t_blk();
        t_same_cycle();
        t_break();
        t_busy_susp();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule